// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle in which `opValid` is high it takes an operation code, the current accumulator value, one operand byte (from a register, memory or an immediate field) and the current carry flag. One clock edge later it presents the result byte, a write strobe naming the result's destination (the accumulator or the operand's own location), and five condition flags: carry, zero, sign, parity and auxiliary (half) carry.

Operand fetch, addressing and instruction decode stay outside. The surrounding machine feeds the block the carry it keeps and writes `resOut` back when a strobe says so. Zero, sign, parity and auxiliary carry live in the block's own flag register, so operations that do not touch them leave them as they were. Carry is passed through from `carryIn` when an operation does not change it.

The work is done by one shared adder/subtractor, three logic functions, a rotator and a complement path. Compare uses the subtractor to set the flags but writes nothing back.

Top module: `accAlu`

## Requirements
- R1: While `rstN` is low, `resValid`, `resOut`, `wrAcc`, `wrOpnd` and all five flag outputs are 0.
- R2: An operation accepted with `opValid` high at a clock edge shows its outputs after that edge with `resValid` high. After an edge with `opValid` low, `resValid`, `wrAcc` and `wrOpnd` are 0, and `resOut` and all flags keep their values.
- R3: Codes 0 (add) and 1 (add with carry) give `resOut` = acc + operand (+ carryIn for code 1) modulo 256, with `wrAcc`. Carry is the carry out of bit 7. Aux is the carry out of bit 3.
- R4: Codes 2 (subtract) and 3 (subtract with borrow) give `resOut` = acc − operand (− carryIn for code 3) modulo 256, with `wrAcc`. Carry is set on a borrow out of bit 7. Aux is set on a borrow out of bit 3.
- R5: Code 4 (compare) sets carry, aux, zero, sign and parity as subtract does, so carry is set when acc < operand and zero when they are equal. It raises neither write strobe, and `resOut` equals the accumulator input.
- R6: Codes 5 (increment) and 6 (decrement) give `resOut` = operand ± 1 modulo 256 with `wrOpnd` only. Carry equals `carryIn`. Aux is set when the low nibble carries (increment of xF) or borrows (decrement of x0).
- R7: Codes 7 (AND), 8 (XOR) and 9 (OR) apply the bitwise function to acc and operand, with `wrAcc`. Carry and aux are cleared.
- R8: Code 10 rotates acc left, moving bit 7 into bit 0 and into carry. Code 11 rotates right, moving bit 0 into bit 7 and into carry. Code 12 rotates the 9-bit value {carry, acc} left and code 13 rotates it right. All four raise `wrAcc` and leave zero, sign, parity and aux unchanged.
- R9: Code 14 writes the complement of acc (`wrAcc`) and keeps every flag (carry = `carryIn`). Code 15 sets carry to the inverse of `carryIn`, and code 16 sets carry to 1. Neither 15 nor 16 raises a write strobe, and both keep the other flags.
- R10: For codes 0 to 9, zero is set when the flag value (the result, or the difference for compare) is 0, sign is its bit 7, and parity is set when it holds an even number of one bits.
- R11: Codes 17 to 31 raise no write strobe. `resOut` equals acc, carry equals `carryIn`, and the other four flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 5 | Operation code (see requirements) |
| accIn | input | 8 | Current accumulator value |
| operand | input | 8 | Register, memory or immediate operand |
| carryIn | input | 1 | Current carry flag |
| resValid | output | 1 | Outputs belong to the operation of the previous cycle |
| resOut | output | 8 | Result byte |
| wrAcc | output | 1 | Write `resOut` to the accumulator |
| wrOpnd | output | 1 | Write `resOut` back to the operand's location |
| flgCarry | output | 1 | Carry / borrow flag |
| flgZero | output | 1 | Zero flag |
| flgSign | output | 1 | Sign flag |
| flgParity | output | 1 | Even-parity flag |
| flgAux | output | 1 | Auxiliary (bit 3) carry flag |

## Verification
The hardest case to reach is a flag that must survive an operation that does not own it. After a rotate or a complement, zero, sign, parity and aux must still show whatever an earlier arithmetic or logic operation left there, so the check depends on the order of operations and not on a single one. Random streams mix all seventeen codes, unused codes and idle cycles back to back, and the bench's model carries the held flags from one operation to the next. Directed cases cover the boundaries: wraps at 0x00 and 0xFF, nibble carries and borrows, compare less, equal and greater, and rotates with both carry values.

// File: rtl/accAluPkg.sv
package accAluPkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_AND = 5'd7,
    OP_XOR = 5'd8,  OP_OR  = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_CMC = 5'd15,
    OP_STC = 5'd16
  } aluOp_e;

  // Source of the flag value / result byte
  typedef enum logic [2:0] {
    RS_ADDER, RS_AND, RS_XOR, RS_OR, RS_ROT, RS_NOT
  } resSel_e;

  // Source of the next carry flag
  typedef enum logic [2:0] {
    CY_KEEP, CY_ADDER, CY_CLEAR, CY_ROT, CY_INV, CY_SET
  } cySel_e;

  // Source of the next auxiliary carry flag
  typedef enum logic [1:0] {
    AC_HOLD, AC_ADDER, AC_CLEAR
  } acSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    resSel_e resSel;
    logic    keepAcc;      // result byte is the accumulator input
    logic    addOnOperand; // adder A side takes the operand (inc/dec)
    logic    unitB;        // adder B side is the constant one
    logic    subMode;
    logic    useCarry;
    logic    rotLeft;
    logic    rotThru;
    cySel_e  cySel;
    logic    updZsp;
    acSel_e  acSel;
    logic    wrAcc;
    logic    wrOpnd;
  } aluCtrl_t;

endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.resSel   = RS_ADDER;
    ctrl.cySel    = CY_KEEP;
    ctrl.acSel    = AC_HOLD;
    ctrl.keepAcc  = 1'b1;

    case (opSel)
      OP_ADD, OP_ADC: begin
        ctrl.useCarry = (opSel == OP_ADC);
        ctrl.cySel    = CY_ADDER;
        ctrl.acSel    = AC_ADDER;
        ctrl.updZsp   = 1'b1;
        ctrl.keepAcc  = 1'b0;
        ctrl.wrAcc    = 1'b1;
      end
      OP_SUB, OP_SBB: begin
        ctrl.subMode  = 1'b1;
        ctrl.useCarry = (opSel == OP_SBB);
        ctrl.cySel    = CY_ADDER;
        ctrl.acSel    = AC_ADDER;
        ctrl.updZsp   = 1'b1;
        ctrl.keepAcc  = 1'b0;
        ctrl.wrAcc    = 1'b1;
      end
      OP_CMP: begin
        ctrl.subMode  = 1'b1;
        ctrl.cySel    = CY_ADDER;
        ctrl.acSel    = AC_ADDER;
        ctrl.updZsp   = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctrl.addOnOperand = 1'b1;
        ctrl.unitB        = 1'b1;
        ctrl.subMode      = (opSel == OP_DEC);
        ctrl.acSel        = AC_ADDER;
        ctrl.updZsp       = 1'b1;
        ctrl.keepAcc      = 1'b0;
        ctrl.wrOpnd       = 1'b1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        ctrl.resSel  = (opSel == OP_AND) ? RS_AND :
                       (opSel == OP_XOR) ? RS_XOR : RS_OR;
        ctrl.cySel   = CY_CLEAR;
        ctrl.acSel   = AC_CLEAR;
        ctrl.updZsp  = 1'b1;
        ctrl.keepAcc = 1'b0;
        ctrl.wrAcc   = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        ctrl.resSel  = RS_ROT;
        ctrl.rotLeft = (opSel == OP_RLC) || (opSel == OP_RAL);
        ctrl.rotThru = (opSel == OP_RAL) || (opSel == OP_RAR);
        ctrl.cySel   = CY_ROT;
        ctrl.keepAcc = 1'b0;
        ctrl.wrAcc   = 1'b1;
      end
      OP_CMA: begin
        ctrl.resSel  = RS_NOT;
        ctrl.keepAcc = 1'b0;
        ctrl.wrAcc   = 1'b1;
      end
      OP_CMC: ctrl.cySel = CY_INV;
      OP_STC: ctrl.cySel = CY_SET;
      default: ;
    endcase
  end

endmodule

// File: rtl/accAluAdder.sv
module accAluAdder #(
  parameter int DW    = 8,
  parameter int NIB_W = 4
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic          subMode,
  input  logic          useCarry,
  input  logic          carryIn,
  output logic [DW-1:0] sum,
  output logic          carryOut,
  output logic          auxOut
);

  logic [DW-1:0]  bEff;
  logic           cinEff;
  logic [DW:0]    full;
  logic [NIB_W:0] nib;

  always_comb begin
    bEff   = subMode ? ~opB : opB;
    // subtraction is A + ~B + 1, with the borrow removing the +1
    if (subMode) cinEff = useCarry ? ~carryIn : 1'b1;
    else         cinEff = useCarry ?  carryIn : 1'b0;
    full = {1'b0, opA} + {1'b0, bEff} + {{DW{1'b0}}, cinEff};
    nib  = {1'b0, opA[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]}
         + {{NIB_W{1'b0}}, cinEff};
    sum      = full[DW-1:0];
    carryOut = subMode ? ~full[DW]    : full[DW];
    auxOut   = subMode ? ~nib[NIB_W]  : nib[NIB_W];
  end

endmodule

// File: rtl/accAluRot.sv
module accAluRot #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val,
  input  logic          rotLeft,
  input  logic          rotThru,
  input  logic          carryIn,
  output logic [DW-1:0] res,
  output logic          carryOut
);

  logic fillLeft;
  logic fillRight;

  always_comb begin
    // bit entering at the vacated end: the moved bit, or the old carry
    fillLeft  = rotThru ? carryIn : val[DW-1];
    fillRight = rotThru ? carryIn : val[0];
    if (rotLeft) begin
      res      = {val[DW-2:0], fillLeft};
      carryOut = val[DW-1];
    end else begin
      res      = {fillRight, val[DW-1:1]};
      carryOut = val[0];
    end
  end

endmodule

// File: rtl/accAluDatapath.sv
module accAluDatapath
  import accAluPkg::*;
#(
  parameter int DW    = 8,
  parameter int NIB_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  aluCtrl_t      ctrl,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] operand,
  input  logic          carryIn,
  output logic          resValid,
  output logic [DW-1:0] resOut,
  output logic          wrAcc,
  output logic          wrOpnd,
  output logic          flgCarry,
  output logic          flgZero,
  output logic          flgSign,
  output logic          flgParity,
  output logic          flgAux
);

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] adderA;
  logic [DW-1:0] adderB;
  logic [DW-1:0] adderSum;
  logic          adderCy;
  logic          adderAc;
  logic [DW-1:0] rotRes;
  logic          rotCy;
  logic [DW-1:0] flagVal;
  logic [DW-1:0] resNext;
  logic          cyNext;

  assign adderA = ctrl.addOnOperand ? operand : accIn;
  assign adderB = ctrl.unitB ? ONE : operand;

  accAluAdder #(.DW(DW), .NIB_W(NIB_W)) uAdder (
    .opA      (adderA),
    .opB      (adderB),
    .subMode  (ctrl.subMode),
    .useCarry (ctrl.useCarry),
    .carryIn  (carryIn),
    .sum      (adderSum),
    .carryOut (adderCy),
    .auxOut   (adderAc)
  );

  accAluRot #(.DW(DW)) uRot (
    .val      (accIn),
    .rotLeft  (ctrl.rotLeft),
    .rotThru  (ctrl.rotThru),
    .carryIn  (carryIn),
    .res      (rotRes),
    .carryOut (rotCy)
  );

  always_comb begin
    case (ctrl.resSel)
      RS_AND:  flagVal = accIn & operand;
      RS_XOR:  flagVal = accIn ^ operand;
      RS_OR:   flagVal = accIn | operand;
      RS_ROT:  flagVal = rotRes;
      RS_NOT:  flagVal = ~accIn;
      default: flagVal = adderSum;
    endcase
    resNext = ctrl.keepAcc ? accIn : flagVal;

    case (ctrl.cySel)
      CY_ADDER: cyNext = adderCy;
      CY_CLEAR: cyNext = 1'b0;
      CY_ROT:   cyNext = rotCy;
      CY_INV:   cyNext = ~carryIn;
      CY_SET:   cyNext = 1'b1;
      default:  cyNext = carryIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resOut    <= '0;
      wrAcc     <= 1'b0;
      wrOpnd    <= 1'b0;
      flgCarry  <= 1'b0;
      flgZero   <= 1'b0;
      flgSign   <= 1'b0;
      flgParity <= 1'b0;
      flgAux    <= 1'b0;
    end else begin
      resValid <= opValid;
      wrAcc    <= opValid & ctrl.wrAcc;
      wrOpnd   <= opValid & ctrl.wrOpnd;
      if (opValid) begin
        resOut   <= resNext;
        flgCarry <= cyNext;
        if (ctrl.updZsp) begin
          flgZero   <= (flagVal == '0);
          flgSign   <= flagVal[DW-1];
          flgParity <= ~(^flagVal);
        end
        case (ctrl.acSel)
          AC_ADDER: flgAux <= adderAc;
          AC_CLEAR: flgAux <= 1'b0;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
#(
  parameter int DW    = 8,
  parameter int NIB_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opSel,
  input  logic [DW-1:0]   accIn,
  input  logic [DW-1:0]   operand,
  input  logic            carryIn,
  output logic            resValid,
  output logic [DW-1:0]   resOut,
  output logic            wrAcc,
  output logic            wrOpnd,
  output logic            flgCarry,
  output logic            flgZero,
  output logic            flgSign,
  output logic            flgParity,
  output logic            flgAux
);

  aluCtrl_t ctrl;

  accAluCtrl uCtrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  accAluDatapath #(.DW(DW), .NIB_W(NIB_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .ctrl      (ctrl),
    .accIn     (accIn),
    .operand   (operand),
    .carryIn   (carryIn),
    .resValid  (resValid),
    .resOut    (resOut),
    .wrAcc     (wrAcc),
    .wrOpnd    (wrOpnd),
    .flgCarry  (flgCarry),
    .flgZero   (flgZero),
    .flgSign   (flgSign),
    .flgParity (flgParity),
    .flgAux    (flgAux)
  );

endmodule

// File: rtl/accAluChecker.sv
module accAluChecker
  import accAluPkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            opValid,
  input logic [OP_W-1:0] opSel,
  input logic [DW-1:0]   accIn,
  input logic [DW-1:0]   operand,
  input logic            carryIn,
  input logic            resValid,
  input logic [DW-1:0]   resOut,
  input logic            wrAcc,
  input logic            wrOpnd,
  input logic            flgCarry,
  input logic            flgZero,
  input logic            flgSign,
  input logic            flgParity,
  input logic            flgAux
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid && !wrAcc && !wrOpnd && $stable(resOut)
                 && $stable(flgCarry) && $stable(flgZero));

  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_CMP) |=> !wrAcc && !wrOpnd && resOut == $past(accIn));

  a_r5_cmp_less: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_CMP && accIn < operand) |=> flgCarry && !flgZero);

  a_r6_incdec_carry: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_INC || opSel == OP_DEC))
      |=> flgCarry == $past(carryIn) && wrOpnd && !wrAcc);

  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_AND || opSel == OP_XOR || opSel == OP_OR))
      |=> !flgCarry && !flgAux);

  a_r8_rot_hold: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel >= OP_RLC && opSel <= OP_RAR)
      |=> $stable(flgZero) && $stable(flgSign) && $stable(flgParity) && $stable(flgAux));

  a_r9_stc_sets: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_STC) |=> flgCarry && !wrAcc && !wrOpnd);

  a_r11_unused_noop: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel > OP_STC)
      |=> !wrAcc && !wrOpnd && flgCarry == $past(carryIn) && $stable(flgZero));

  a_r1_single_dest: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAcc && wrOpnd));

endmodule

bind accAlu accAluChecker #(.DW(DW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opSel     (opSel),
  .accIn     (accIn),
  .operand   (operand),
  .carryIn   (carryIn),
  .resValid  (resValid),
  .resOut    (resOut),
  .wrAcc     (wrAcc),
  .wrOpnd    (wrOpnd),
  .flgCarry  (flgCarry),
  .flgZero   (flgZero),
  .flgSign   (flgSign),
  .flgParity (flgParity),
  .flgAux    (flgAux)
);

// File: tb/tb_accAlu.sv
module tb_accAlu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] accIn = '0;
  logic [7:0] operand = '0;
  logic       carryIn = 1'b0;

  logic       resValid, wrAcc, wrOpnd;
  logic [7:0] resOut;
  logic       flgCarry, flgZero, flgSign, flgParity, flgAux;

  always #5 clk = ~clk;

  accAlu #(.DW(8), .NIB_W(4)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .accIn(accIn), .operand(operand), .carryIn(carryIn),
    .resValid(resValid), .resOut(resOut), .wrAcc(wrAcc), .wrOpnd(wrOpnd),
    .flgCarry(flgCarry), .flgZero(flgZero), .flgSign(flgSign),
    .flgParity(flgParity), .flgAux(flgAux)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state carried between operations
  int eRes = 0, eCy = 0, eZ = 0, eS = 0, eP = 0, eA = 0;

  task automatic check1(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(int op);
    case (op)
      0, 1:           return "R3";
      2, 3:           return "R4";
      4:              return "R5";
      5, 6:           return "R6";
      7, 8, 9:        return "R7";
      10, 11, 12, 13: return "R8";
      14, 15, 16:     return "R9";
      default:        return "R11";
    endcase
  endfunction

  task automatic runOp(int op, int a, int b, int c);
    int r, fv, t, ci, nAc, wa, wo, cy, upd, acm;
    logic [7:0] fv8;
    string tag;
    tag = tagOf(op);
    r = a; fv = 0; wa = 0; wo = 0; cy = c; upd = 0; acm = 0; nAc = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? c : 0;
        t = a + b + ci; fv = t & 255; cy = (t > 255) ? 1 : 0;
        nAc = (((a & 15) + (b & 15) + ci) > 15) ? 1 : 0;
        upd = 1; acm = 1; r = fv; wa = 1;
      end
      2, 3, 4: begin
        ci = (op == 3) ? c : 0;
        t = a - b - ci; fv = t & 255; cy = (t < 0) ? 1 : 0;
        nAc = (((a & 15) - (b & 15) - ci) < 0) ? 1 : 0;
        upd = 1; acm = 1;
        if (op != 4) begin r = fv; wa = 1; end
      end
      5: begin fv = (b + 1) & 255; nAc = ((b & 15) == 15) ? 1 : 0;
               upd = 1; acm = 1; r = fv; wo = 1; end
      6: begin fv = (b + 255) & 255; nAc = ((b & 15) == 0) ? 1 : 0;
               upd = 1; acm = 1; r = fv; wo = 1; end
      7, 8, 9: begin
        fv = (op == 7) ? (a & b) : (op == 8) ? (a ^ b) : (a | b);
        cy = 0; nAc = 0; upd = 1; acm = 1; r = fv; wa = 1;
      end
      10: begin r = ((a << 1) | (a >> 7)) & 255; cy = (a >> 7) & 1; wa = 1; end
      11: begin r = (a >> 1) | ((a & 1) << 7);   cy = a & 1;        wa = 1; end
      12: begin r = ((a << 1) | c) & 255;        cy = (a >> 7) & 1; wa = 1; end
      13: begin r = (a >> 1) | (c << 7);         cy = a & 1;        wa = 1; end
      14: begin r = (~a) & 255; wa = 1; end
      15: cy = (c == 0) ? 1 : 0;
      16: cy = 1;
      default: ;
    endcase
    fv8 = fv[7:0];
    eRes = r; eCy = cy;
    if (upd != 0) begin
      eZ = (fv8 == 8'h00) ? 1 : 0;
      eS = int'(fv8[7]);
      eP = ($countones(fv8) % 2 == 0) ? 1 : 0;
    end
    if (acm != 0) eA = nAc;

    opValid = 1'b1; opSel = op[4:0]; accIn = a[7:0]; operand = b[7:0]; carryIn = c[0];
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    check1("R2", "resValid", int'(resValid), 1);
    check1(tag, "resOut", int'(resOut), eRes);
    check1(tag, "wrAcc", int'(wrAcc), wa);
    check1(tag, "wrOpnd", int'(wrOpnd), wo);
    check1(tag, "carry", int'(flgCarry), eCy);
    check1(tag, "aux", int'(flgAux), eA);
    if (upd != 0) begin
      check1("R10", "zero", int'(flgZero), eZ);
      check1("R10", "sign", int'(flgSign), eS);
      check1("R10", "parity", int'(flgParity), eP);
    end else begin
      check1(tag, "zero held", int'(flgZero), eZ);
      check1(tag, "sign held", int'(flgSign), eS);
      check1(tag, "parity held", int'(flgParity), eP);
    end
  endtask

  task automatic idleCycle();
    opValid = 1'b0;
    accIn = 8'($urandom); operand = 8'($urandom); carryIn = 1'($urandom);
    @(posedge clk);
    @(negedge clk);
    check1("R2", "idle resValid", int'(resValid), 0);
    check1("R2", "idle strobes", int'({wrAcc, wrOpnd}), 0);
    check1("R2", "idle resOut", int'(resOut), eRes);
    check1("R2", "idle flags", int'({flgCarry, flgZero, flgSign, flgParity, flgAux}),
           (eCy << 4) | (eZ << 3) | (eS << 2) | (eP << 1) | eA);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    // R1: reset state, with activity on the inputs
    opValid = 1'b1; opSel = 5'd0; accIn = 8'hFF; operand = 8'h01; carryIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R1", "reset outputs",
           int'({resValid, resOut, wrAcc, wrOpnd, flgCarry, flgZero, flgSign, flgParity, flgAux}), 0);
    opValid = 1'b0;
    rstN = 1'b1;
    idleCycle();

    // directed corners
    runOp(0, 8'hFF, 8'h01, 0);   // R3 wrap, carry + aux + zero
    runOp(1, 8'hFF, 8'h00, 1);   // R3 carry-in wrap
    runOp(1, 8'h0E, 8'h01, 1);   // R3 nibble carry via carry-in
    runOp(2, 8'h00, 8'h01, 0);   // R4 borrow
    runOp(3, 8'h10, 8'h00, 1);   // R4 nibble borrow via carry-in
    runOp(4, 8'h42, 8'h42, 0);   // R5 equal
    runOp(4, 8'h10, 8'h20, 0);   // R5 less
    runOp(4, 8'h80, 8'h01, 1);   // R5 greater
    runOp(5, 8'h00, 8'hFF, 1);   // R6 increment wrap keeps carry
    runOp(6, 8'h00, 8'h00, 0);   // R6 decrement wrap
    runOp(6, 8'h00, 8'h10, 1);   // R6 nibble borrow
    runOp(7, 8'hF0, 8'h0F, 1);   // R7 AND to zero
    runOp(8, 8'hAA, 8'h55, 1);   // R7 XOR
    runOp(9, 8'h00, 8'h81, 1);   // R7 OR
    runOp(10, 8'h81, 8'h00, 0);  // R8 rotate left
    runOp(11, 8'h01, 8'h00, 0);  // R8 rotate right
    runOp(12, 8'h7F, 8'h00, 1);  // R8 left through carry
    runOp(13, 8'hFE, 8'h00, 1);  // R8 right through carry
    runOp(14, 8'h3C, 8'h00, 1);  // R9 complement acc
    runOp(15, 8'h00, 8'h00, 1);  // R9 complement carry
    runOp(16, 8'h00, 8'h00, 0);  // R9 set carry
    runOp(17, 8'h12, 8'h34, 1);  // R11 unused low
    runOp(31, 8'h56, 8'h78, 0);  // R11 unused high
    idleCycle();

    // constrained random mix
    for (int i = 0; i < 20000; i++) begin
      int op;
      if (($urandom % 16) == 0) idleCycle();
      if (($urandom % 10) == 0) op = 17 + int'($urandom % 15);
      else                      op = int'($urandom % 17);
      runOp(op, int'($urandom % 256), int'($urandom % 256), int'($urandom % 2));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule